// File: doc/BRIEF.md
# TDMA Slot Selection Engine

This block chooses the time slot in which a station will next transmit on a shared two-channel radio link. Each frame has 2250 slot indices. For each channel the engine keeps a bitmap that marks which slots are already taken. The host marks and clears these bits one at a time. When the host starts a selection, it gives a channel and a window of candidate slots. The engine steps through the window in order and passes over occupied slots. For each free slot it draws a pseudo-random number and accepts the slot if the draw is at or below a persistence threshold. Each refusal raises the threshold, so a later free candidate is more likely to be accepted than an earlier one.

The accepted slot index is held on an output, ready to be announced to other stations ahead of use. The engine then counts frame ticks to measure how long the reservation has been held. When the hold limit is reached it asks the host for a new selection. A rate-change event drops the reservation at once and marks the next selection as an initial network entry.

Top module: `tdma_slot_picker`

## Requirements
- R1: After reset, done, busy, fail and resv_valid are 0, next_slot is 0, and both reselect_req and first_entry are 1.
- R2: A cycle with occ_we high sets bit occ_slot of channel occ_ch to occ_busy (1 = occupied, 0 = free). The two channels are independent of each other. Occupied candidates are passed over without drawing a random value.
- R3: Candidates are visited in this order: win_start, then win_start+1, and so on, wrapping from slot 2249 to slot 0. After win_len candidates the scan returns to win_start. A win_len of 0 is treated as 1, and a win_len above 2250 is treated as 2250.
- R4: The random source is a 16-bit register seeded to 0xACE1. Each step shifts it left and inserts bit15^bit13^bit12^bit10 as the new bit 0. One draw is one step, and the draw value is bits [6:0] of the new state. Draws above 100 are discarded and redrawn, and each redraw is a further step. The register steps only while drawing.
- R5: A free candidate is accepted when draw <= threshold. The threshold is 5 at start. Each refused free candidate adds 10 to it, with saturation at 255. The raised threshold is kept when the scan wraps back to win_start.
- R6: On acceptance, done is high for exactly one cycle, fail is 0, next_slot shows the accepted slot until the next acceptance, and resv_valid becomes 1.
- R7: If a full pass over the window finds no free candidate, the engine stops with a one-cycle done and fail = 1. next_slot keeps its previous value.
- R8: Once a reservation is held, the 7th frame_tick pulse after acceptance clears resv_valid and sets reselect_req. Fewer than 7 pulses leave both unchanged.
- R9: A rate_change pulse clears resv_valid and sets both reselect_req and first_entry. An accepted start clears reselect_req. A successful selection clears first_entry.
- R10: A start that arrives while a selection is running (busy = 1) is ignored. It does not change the result of the running selection and does not step the random source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_we | input | 1 | Occupancy write strobe |
| occ_ch | input | 1 | Channel for the occupancy write |
| occ_slot | input | 12 | Slot index for the occupancy write |
| occ_busy | input | 1 | Value to write: 1 = occupied, 0 = free |
| start | input | 1 | Start a selection (ignored while busy) |
| pick_ch | input | 1 | Channel to select on |
| win_start | input | 12 | First candidate slot index |
| win_len | input | 12 | Number of candidates in the window |
| frame_tick | input | 1 | One pulse per frame, for the hold timer |
| rate_change | input | 1 | Speed-change event |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle end-of-selection pulse |
| fail | output | 1 | Last selection found no free slot |
| next_slot | output | 12 | Slot to announce and transmit in |
| resv_valid | output | 1 | A reservation is currently held |
| reselect_req | output | 1 | A new selection is needed |
| first_entry | output | 1 | Next selection is an initial network entry |

## Verification
Any error in the random register, the threshold, or the candidate pointer changes which slot is accepted. The error therefore shows on next_slot at the next done pulse, and every later selection is also affected because the random state carries over between selections. A bitmap write to the wrong bit or the wrong channel shows up as an accepted slot that should have been skipped, or as a fail on a window that has a free slot. A hold counter that is off by even one frame moves the falling edge of resv_valid to a different frame_tick pulse.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DRAW = 2'd2
   } pick_state_t;
endpackage

// File: rtl/tdma_rand_src.sv
module tdma_rand_src #(
   parameter int LFSR_W = 16,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
   parameter int OUT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [OUT_W-1:0]  draw
);
   logic [LFSR_W-1:0] state;
   logic              fb;

   if (OUT_W > LFSR_W) begin : g_bad_out
      $error("tdma_rand_src: OUT_W exceeds LFSR_W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("tdma_rand_src: seed must be nonzero");
   end

   if (LFSR_W == 16) begin : g_taps16
      assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];
   end else if (LFSR_W == 24) begin : g_taps24
      assign fb = state[23] ^ state[22] ^ state[21] ^ state[16];
   end else if (LFSR_W == 32) begin : g_taps32
      assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];
   end else begin : g_taps_bad
      assign fb = 1'b0;
      $error("tdma_rand_src: unsupported LFSR_W");
   end

   logic [LFSR_W-1:0] nxt;
   assign nxt  = {state[LFSR_W-2:0], fb};
   assign draw = nxt[OUT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= nxt;
   end

   assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
   assert_lfsr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(step) |-> $stable(state));
endmodule

// File: rtl/tdma_occ_map.sv
module tdma_occ_map #(
   parameter int NUM_SLOTS = 2250,
   parameter int NUM_CH    = 2,
   localparam int SW   = $clog2(NUM_SLOTS),
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CH_W-1:0] wr_ch,
   input  logic [SW-1:0]   wr_slot,
   input  logic            wr_busy,
   input  logic [CH_W-1:0] rd_ch,
   input  logic [SW-1:0]   rd_slot,
   output logic            rd_busy
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("tdma_occ_map: need at least one channel");
   end

   logic [NUM_CH-1:0] per_ch_rd;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NUM_SLOTS-1:0] bits;
      always_ff @(posedge clk) begin
         if (!rst_n) bits <= '0;
         else if (we && (wr_ch == CH_W'(c)) && (int'(wr_slot) < NUM_SLOTS))
            bits[wr_slot] <= wr_busy;
      end
      assign per_ch_rd[c] = (int'(rd_slot) < NUM_SLOTS) ? bits[rd_slot] : 1'b1;

      assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(we) && ($past(wr_ch) == CH_W'(c)) && (int'($past(wr_slot)) < NUM_SLOTS))
         |-> (bits[$past(wr_slot)] == $past(wr_busy)));
   end

   assign rd_busy = (int'(rd_ch) < NUM_CH) ? per_ch_rd[rd_ch] : 1'b1;
endmodule

// File: rtl/tdma_hold_timer.sv
module tdma_hold_timer #(
   parameter int HOLD_FRAMES = 7,
   localparam int CNT_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic start_ack,
   input  logic frame_tick,
   input  logic rate_change,
   output logic held,
   output logic reselect_req,
   output logic first_entry
);
   if (HOLD_FRAMES < 1) begin : g_bad_hold
      $error("tdma_hold_timer: HOLD_FRAMES must be positive");
   end

   logic [CNT_W-1:0] cnt;
   logic             expire;

   assign expire = held && frame_tick && !grant && (cnt == CNT_W'(HOLD_FRAMES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held         <= 1'b0;
         cnt          <= '0;
         reselect_req <= 1'b1;
         first_entry  <= 1'b1;
      end else if (rate_change) begin
         held         <= 1'b0;
         cnt          <= '0;
         reselect_req <= 1'b1;
         first_entry  <= 1'b1;
      end else begin
         if (grant) begin
            held        <= 1'b1;
            cnt         <= '0;
            first_entry <= 1'b0;
         end else if (expire) begin
            held <= 1'b0;
            cnt  <= '0;
         end else if (held && frame_tick) begin
            cnt <= cnt + 1'b1;
         end
         if (expire)         reselect_req <= 1'b1;
         else if (start_ack) reselect_req <= 1'b0;
      end
   end

   assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt} < (CNT_W+1)'(HOLD_FRAMES));
   assert_drop_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held) |-> reselect_req);
   assert_rate_reenters_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rate_change) |-> (first_entry && reselect_req && !held));
endmodule

// File: rtl/tdma_pick_fsm.sv
module tdma_pick_fsm
   import tdma_pkg::*;
#(
   parameter int NUM_SLOTS = 2250,
   parameter int NUM_CH    = 2,
   parameter int DRAW_W    = 7,
   parameter int RAND_MAX  = 100,
   parameter int THR_W     = 8,
   parameter int THR_INIT  = 5,
   parameter int THR_STEP  = 10,
   localparam int SW    = $clog2(NUM_SLOTS),
   localparam int LEN_W = $clog2(NUM_SLOTS + 1),
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CH_W-1:0]   pick_ch,
   input  logic [SW-1:0]     win_start,
   input  logic [LEN_W-1:0]  win_len,
   input  logic              cand_busy,
   input  logic [DRAW_W-1:0] draw,
   output logic [CH_W-1:0]   rd_ch,
   output logic [SW-1:0]     rd_slot,
   output logic              step,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [SW-1:0]     next_slot,
   output logic              grant,
   output logic              start_ack
);
   localparam int THR_MAX = (1 << THR_W) - 1;

   if (RAND_MAX >= (1 << DRAW_W)) begin : g_bad_range
      $error("tdma_pick_fsm: RAND_MAX does not fit DRAW_W");
   end
   if (THR_W < DRAW_W || THR_INIT > THR_MAX) begin : g_bad_thr
      $error("tdma_pick_fsm: threshold width or start value invalid");
   end

   pick_state_t       state;
   logic [CH_W-1:0]   cur_ch;
   logic [SW-1:0]     base, cand;
   logic [LEN_W-1:0]  len, offs;
   logic [THR_W-1:0]  thr;
   logic              seen;

   logic [LEN_W-1:0]  eff_len;
   logic [SW-1:0]     eff_start;
   logic              in_range, accept, last_cand;
   logic [THR_W:0]    thr_sum;
   logic [THR_W-1:0]  thr_up;
   logic [SW-1:0]     cand_inc;

   always_comb begin
      if (win_len == '0)                         eff_len = LEN_W'(1);
      else if (int'(win_len) > NUM_SLOTS)        eff_len = LEN_W'(NUM_SLOTS);
      else                                       eff_len = win_len;
      eff_start = (int'(win_start) < NUM_SLOTS) ? win_start : '0;
   end

   assign in_range  = int'(draw) <= RAND_MAX;
   assign accept    = in_range && ({{(THR_W-DRAW_W){1'b0}}, draw} <= thr);
   assign last_cand = (offs == len - 1'b1);
   assign thr_sum   = {1'b0, thr} + (THR_W+1)'(THR_STEP);
   assign thr_up    = (int'(thr_sum) > THR_MAX) ? THR_W'(THR_MAX) : thr_sum[THR_W-1:0];
   assign cand_inc  = (int'(cand) == NUM_SLOTS - 1) ? '0 : cand + 1'b1;

   assign rd_ch     = cur_ch;
   assign rd_slot   = cand;
   assign busy      = (state != ST_IDLE);
   assign step      = (state == ST_DRAW);
   assign start_ack = (state == ST_IDLE) && start;
   assign grant     = (state == ST_DRAW) && accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_ch    <= '0;
         base      <= '0;
         cand      <= '0;
         len       <= LEN_W'(1);
         offs      <= '0;
         thr       <= THR_W'(THR_INIT);
         seen      <= 1'b0;
         done      <= 1'b0;
         fail      <= 1'b0;
         next_slot <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cur_ch <= pick_ch;
                  base   <= eff_start;
                  cand   <= eff_start;
                  len    <= eff_len;
                  offs   <= '0;
                  thr    <= THR_W'(THR_INIT);
                  seen   <= 1'b0;
                  state  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (!cand_busy) begin
                  seen  <= 1'b1;
                  state <= ST_DRAW;
               end else if (last_cand) begin
                  if (!seen) begin
                     done  <= 1'b1;
                     fail  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     offs <= '0;
                     cand <= base;
                     seen <= 1'b0;
                  end
               end else begin
                  offs <= offs + 1'b1;
                  cand <= cand_inc;
               end
            end
            ST_DRAW: begin
               if (accept) begin
                  done      <= 1'b1;
                  fail      <= 1'b0;
                  next_slot <= cand;
                  state     <= ST_IDLE;
               end else if (in_range) begin
                  thr   <= thr_up;
                  state <= ST_SCAN;
                  if (last_cand) begin
                     offs <= '0;
                     cand <= base;
                     seen <= 1'b0;
                  end else begin
                     offs <= offs + 1'b1;
                     cand <= cand_inc;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_done_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(state != ST_IDLE));
   assert_thr_never_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state != ST_IDLE) && $past(state != ST_IDLE)) |-> (thr >= $past(thr)));
   assert_offs_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> (offs < len));
   assert_fail_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);
endmodule

// File: rtl/tdma_slot_picker.sv
module tdma_slot_picker #(
   parameter int NUM_SLOTS   = 2250,
   parameter int NUM_CH      = 2,
   parameter int LFSR_W      = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter int RAND_MAX    = 100,
   parameter int THR_W       = 8,
   parameter int THR_INIT    = 5,
   parameter int THR_STEP    = 10,
   parameter int HOLD_FRAMES = 7,
   localparam int SW     = $clog2(NUM_SLOTS),
   localparam int LEN_W  = $clog2(NUM_SLOTS + 1),
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int DRAW_W = $clog2(RAND_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             occ_we,
   input  logic [CH_W-1:0]  occ_ch,
   input  logic [SW-1:0]    occ_slot,
   input  logic             occ_busy,
   input  logic             start,
   input  logic [CH_W-1:0]  pick_ch,
   input  logic [SW-1:0]    win_start,
   input  logic [LEN_W-1:0] win_len,
   input  logic             frame_tick,
   input  logic             rate_change,
   output logic             busy,
   output logic             done,
   output logic             fail,
   output logic [SW-1:0]    next_slot,
   output logic             resv_valid,
   output logic             reselect_req,
   output logic             first_entry
);
   logic [CH_W-1:0]   rd_ch;
   logic [SW-1:0]     rd_slot;
   logic              rd_busy, step, grant, start_ack;
   logic [DRAW_W-1:0] draw;

   tdma_occ_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH)) u_map (
      .clk, .rst_n,
      .we(occ_we), .wr_ch(occ_ch), .wr_slot(occ_slot), .wr_busy(occ_busy),
      .rd_ch(rd_ch), .rd_slot(rd_slot), .rd_busy(rd_busy)
   );

   tdma_rand_src #(.LFSR_W(LFSR_W), .SEED(LFSR_SEED), .OUT_W(DRAW_W)) u_rand (
      .clk, .rst_n, .step(step), .draw(draw)
   );

   tdma_pick_fsm #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH), .DRAW_W(DRAW_W), .RAND_MAX(RAND_MAX),
      .THR_W(THR_W), .THR_INIT(THR_INIT), .THR_STEP(THR_STEP)
   ) u_fsm (
      .clk, .rst_n,
      .start(start), .pick_ch(pick_ch), .win_start(win_start), .win_len(win_len),
      .cand_busy(rd_busy), .draw(draw),
      .rd_ch(rd_ch), .rd_slot(rd_slot), .step(step), .busy(busy),
      .done(done), .fail(fail), .next_slot(next_slot),
      .grant(grant), .start_ack(start_ack)
   );

   tdma_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_timer (
      .clk, .rst_n,
      .grant(grant), .start_ack(start_ack), .frame_tick(frame_tick),
      .rate_change(rate_change),
      .held(resv_valid), .reselect_req(reselect_req), .first_entry(first_entry)
   );
endmodule

// File: tb/tdma_slot_picker_bench.sv
module tdma_slot_picker_bench;
   localparam int NS = 2250;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        occ_we = 1'b0, occ_ch = 1'b0, occ_busy = 1'b0;
   logic [11:0] occ_slot = '0;
   logic        start = 1'b0, pick_ch = 1'b0;
   logic [11:0] win_start = '0, win_len = '0;
   logic        frame_tick = 1'b0, rate_change = 1'b0;
   logic        busy, done, fail, resv_valid, reselect_req, first_entry;
   logic [11:0] next_slot;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   bit [NS-1:0] m_occ [2];
   logic [15:0] m_lfsr = 16'hACE1;
   int          last_slot = 0;

   always #10 clk = ~clk;

   tdma_slot_picker u_tdma_slot_picker (
      .clk, .rst_n, .occ_we, .occ_ch, .occ_slot, .occ_busy,
      .start, .pick_ch, .win_start, .win_len, .frame_tick, .rate_change,
      .busy, .done, .fail, .next_slot, .resv_valid, .reselect_req, .first_entry
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // Bench model from R3, R4, R5, R7
   function automatic void model_pick(input int ch, input int ws, input int wl,
                                      output int slot, output bit fl);
      int len, offs, thr, cand, r, guard;
      bit seen;
      len = (wl == 0) ? 1 : ((wl > NS) ? NS : wl);
      offs = 0; thr = 5; seen = 0; fl = 0; slot = -1;
      for (guard = 0; guard < 100000; guard++) begin
         cand = (ws + offs) % NS;
         if (!m_occ[ch][cand]) begin
            seen = 1;
            do begin
               m_lfsr = lfsr_next(m_lfsr);
               r = int'(m_lfsr[6:0]);
            end while (r > 100);
            if (r <= thr) begin slot = cand; return; end
            thr = (thr + 10 > 255) ? 255 : thr + 10;
         end else if (offs == len - 1 && !seen) begin
            fl = 1; return;
         end
         if (offs == len - 1) begin offs = 0; seen = 0; end
         else offs++;
      end
      fl = 1;
   endfunction

   task automatic set_occ(input int ch, input int slot, input bit v);
      @(negedge clk);
      occ_we = 1'b1; occ_ch = ch[0]; occ_slot = 12'(slot); occ_busy = v;
      @(negedge clk);
      occ_we = 1'b0;
      m_occ[ch][slot] = v;
   endtask

   task automatic wait_done(input string req, output bit seen);
      seen = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; break; end
      end
      if (!seen) check(1'b0, req, "done never seen", 0, 1);
   endtask

   task automatic pick(input int ch, input int ws, input int wl, input string req);
      int exp_slot; bit exp_fail, seen;
      model_pick(ch, ws, wl, exp_slot, exp_fail);
      @(negedge clk);
      start = 1'b1; pick_ch = ch[0]; win_start = 12'(ws); win_len = 12'(wl);
      @(negedge clk);
      start = 1'b0;
      wait_done(req, seen);
      if (seen) begin
         check(fail == exp_fail, req, "fail flag", int'(fail), int'(exp_fail));
         if (exp_fail) begin
            check(int'(next_slot) == last_slot, "R7", "next_slot kept on fail",
                  int'(next_slot), last_slot);
         end else begin
            check(int'(next_slot) == exp_slot, req, "chosen slot", int'(next_slot), exp_slot);
            check(resv_valid == 1'b1, "R6", "resv_valid after pick", int'(resv_valid), 1);
            last_slot = exp_slot;
         end
         @(negedge clk);
         check(done == 1'b0, "R6", "done lasts one cycle", int'(done), 0);
      end
   endtask

   task automatic pulse_tick();
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      int exp_slot; bit exp_fail, seen;
      void'($urandom(32'd4711));
      m_occ[0] = '0; m_occ[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(done == 0 && busy == 0 && fail == 0, "R1", "done/busy/fail", int'({done, busy, fail}), 0);
      check(resv_valid == 0, "R1", "resv_valid", int'(resv_valid), 0);
      check(next_slot == 0, "R1", "next_slot", int'(next_slot), 0);
      check(reselect_req && first_entry, "R1", "reselect_req/first_entry",
            int'({reselect_req, first_entry}), 3);

      // R2 channel independence and R7 single occupied slot
      set_occ(0, 10, 1'b1);
      pick(0, 10, 1, "R2");
      check(fail == 1'b1, "R2", "occupied ch0 slot gives fail", int'(fail), 1);
      pick(1, 10, 1, "R2");
      check(int'(next_slot) == 10, "R2", "ch1 slot 10 is free", int'(next_slot), 10);
      check(reselect_req == 1'b0, "R9", "start clears reselect_req", int'(reselect_req), 0);
      check(first_entry == 1'b0, "R9", "pick clears first_entry", int'(first_entry), 0);

      // R3 window wraps across frame end
      set_occ(0, 2248, 1'b1); set_occ(0, 2249, 1'b1);
      pick(0, 2248, 5, "R3");
      // R3 window length zero treated as one
      pick(1, 500, 0, "R3");

      // R7 all occupied window of 20
      for (int s = 100; s < 120; s++) set_occ(1, s, 1'b1);
      pick(1, 100, 20, "R7");
      // R5 one free slot in long window: repeated passes keep raised threshold
      set_occ(1, 119, 1'b0);
      pick(1, 100, 20, "R5");

      // R10 start while busy is ignored
      for (int s = 300; s < 308; s++) set_occ(0, s, 1'b1);
      model_pick(0, 300, 40, exp_slot, exp_fail);
      @(negedge clk);
      start = 1'b1; pick_ch = 1'b0; win_start = 12'd300; win_len = 12'd40;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R10", "busy during scan", int'(busy), 1);
      start = 1'b1; pick_ch = 1'b1; win_start = 12'd900; win_len = 12'd3;
      @(negedge clk);
      start = 1'b0;
      wait_done("R10", seen);
      if (seen) begin
         check(int'(next_slot) == exp_slot, "R10", "slot unaffected by late start",
               int'(next_slot), exp_slot);
         last_slot = exp_slot;
      end
      // later result proves random source was not stepped by ignored start
      pick(0, 1500, 30, "R10");

      // R4/R5 random windows with random occupancy
      for (int t = 0; t < 24; t++) begin
         int ch, ws, wl;
         ch = int'($urandom % 2);
         ws = int'($urandom % NS);
         wl = 1 + int'($urandom % 30);
         for (int k = 0; k < wl; k++)
            set_occ(ch, (ws + k) % NS, (t % 6 == 5) ? 1'b1 : bit'($urandom % 2));
         pick(ch, ws, wl, (t % 2 == 0) ? "R4" : "R5");
      end
      for (int k = 0; k < 30; k++) set_occ(0, 2000 + k, 1'b0);
      pick(0, 2000, 30, "R4");

      // R8 hold timer
      for (int i = 0; i < 6; i++) pulse_tick();
      check(resv_valid == 1'b1, "R8", "held after 6 ticks", int'(resv_valid), 1);
      check(reselect_req == 1'b0, "R8", "no request after 6 ticks", int'(reselect_req), 0);
      pulse_tick();
      check(resv_valid == 1'b0, "R8", "dropped at 7th tick", int'(resv_valid), 0);
      check(reselect_req == 1'b1, "R8", "request at 7th tick", int'(reselect_req), 1);
      check(first_entry == 1'b0, "R8", "timeout is not re-entry", int'(first_entry), 0);

      // R9 rate change
      pick(0, 2000, 30, "R9");
      @(negedge clk); rate_change = 1'b1;
      @(negedge clk); rate_change = 1'b0;
      check(resv_valid == 1'b0, "R9", "rate_change drops hold", int'(resv_valid), 0);
      check(reselect_req && first_entry, "R9", "rate_change re-entry flags",
            int'({reselect_req, first_entry}), 3);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule